// File: doc/BRIEF.md
# DRAM Chip-Select Window Decoder

This block maps a 36-bit physical address onto one of a small set of DRAM chip-select windows. Software programs each window through a 32-bit register port. Each window has two registers. The base register places the window on a 16 MiB boundary, anywhere in the 64 GiB space. The size register holds an enable bit, the chip-select to report on a hit, and a size code counted in 16 MiB units.

A lookup is presented with a valid strobe. One clock later the block returns three results: a hit flag, the chip-select of the matching window, and an 8-bit bus attribute for that window. The attribute carries a 4-bit mask with the window's own bit cleared, plus a coherency flag taken from an input pin.

Two outputs are available without any lookup. The first gives one flag per window saying whether it starts below 4 GiB. The second counts the enabled windows that 32-bit DMA engines can reach, so that system software or a neighbouring DMA block can read it directly.

Top module: `dram_cs_decoder`

## Requirements
- R1: After a synchronous active-low reset, every window register reads zero. Every window is therefore disabled, `num_cs` is 0 and every lookup misses.
- R2: Register offsets are decoded as follows. Bits [4:3] select the window. Bit 2 selects the size register (1) or the base register (0). Bits [1:0] are ignored.
  - Base register: bits [31:24] hold address bits [31:24] and bits [3:0] hold address bits [35:32].
  - Size register: bit 0 is the enable, bits [4:2] are the chip-select and bits [31:24] are the size code.
  - Every other bit is discarded on write and reads back as zero.
- R3: An enabled window covers (code+1)·16 MiB starting at its base, for sizes that are a power of two aligned to the base. An address matches when bits [35:32] equal the base high nibble and bits [31:24] equal the base byte in every bit position where the size code holds 0.
- R4: A window whose enable bit is 0 never matches, whatever its base and size.
- R5: When several windows match, the lowest window index wins. `res_cs` then reports that window's chip-select field.
- R6: On a hit, `res_attr` is formed as follows. Bits [3:0] are 0xF with the bit of the winning window index cleared. Bit 4 equals `coh_en` as sampled with the lookup. Bits [7:5] are 0.
- R7: On a miss, `res_hit`, `res_cs` and `res_attr` are all 0.
- R8: The result appears with `res_valid` high exactly one cycle after `lookup_valid`. Lookups may be issued on consecutive cycles, and `res_valid` is low in a cycle that follows no lookup.
- R9: `win_lo4g[i]` is 1 exactly when window i's base high nibble is 0, whether or not the window is enabled.
- R10: `num_cs` equals the number of enabled windows whose base high nibble is 0. It changes only in the cycle after a register write.
- R11: A lookup issued in the same cycle as a register write is decoded with the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 5 | Register write byte offset |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_addr | input | 5 | Register read byte offset |
| cfg_rd_data | output | 32 | Register read data (combinational) |
| coh_en | input | 1 | Coherency flag copied into attribute bit 4 |
| lookup_valid | input | 1 | Lookup request strobe |
| lookup_addr | input | 36 | Physical address to decode |
| res_valid | output | 1 | Result valid, one cycle after request |
| res_hit | output | 1 | Address fell inside an enabled window |
| res_cs | output | 3 | Chip-select of the winning window |
| res_attr | output | 8 | Bus attribute of the winning window |
| win_lo4g | output | 4 | Per-window flag: base below 4 GiB |
| num_cs | output | 3 | Enabled windows below 4 GiB |

## Verification
The bench builds the block with its default of four windows, which gives a 5-bit register offset, a 3-bit count and the full 4-bit attribute mask. With four windows, one window can be placed above 4 GiB while two others overlap at the bottom of memory, so lowest-index priority, the high-nibble compare and the split between enabled and DMA-reachable windows all occur in one programmed map. That four-window setting also lets every window be the winner once, so each cleared mask bit position is seen in an attribute.

// File: rtl/csw_pkg.sv
// Package: shared field positions and the per-window configuration type
// for the DRAM chip-select window decoder.
// Assumes the register layout is fixed at 32 bits and the address at 36 bits.
package csw_pkg;

    localparam int REG_W      = 32;
    localparam int ADDR_W     = 36;
    localparam int GRAN_LSB   = 24;               // 16 MiB granularity
    localparam int LO_W       = 32 - GRAN_LSB;    // base/size byte width
    localparam int HI_W       = ADDR_W - 32;      // address bits above 4 GiB
    localparam int CS_W       = 3;
    localparam int CS_LSB     = 2;
    localparam int EN_BIT     = 0;
    localparam int ATTR_W     = 8;
    localparam int MASK_W     = 4;                // attribute mask nibble
    localparam int COH_BIT    = 4;

    typedef struct packed {
        logic [LO_W-1:0] base_lo;   // address bits 31:24
        logic [HI_W-1:0] base_hi;   // address bits 35:32
        logic [LO_W-1:0] size_code; // (code+1) * 16 MiB
        logic [CS_W-1:0] cs;        // chip-select to report
        logic            en;        // window enable
    } win_cfg_t;

endpackage

// File: rtl/csw_regfile.sv
// Module: register storage for the window set.
// Holds only the defined fields of each base and size register, decodes the
// write offset (window in bits [AW-1:3], size/base in bit 2, bits 1:0 ignored)
// and returns a zero-filled read image. Assumes NUM_WIN is a power of two >= 2.
module csw_regfile #(
    parameter int NUM_WIN = 4,
    parameter int IDX_W   = $clog2(NUM_WIN),
    parameter int AW      = IDX_W + 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [AW-1:0]                       wr_addr,
    input  logic [csw_pkg::REG_W-1:0]           wr_data,
    input  logic [AW-1:0]                       rd_addr,
    output logic [csw_pkg::REG_W-1:0]           rd_data,
    output csw_pkg::win_cfg_t [NUM_WIN-1:0]     cfg
);
    import csw_pkg::*;

    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [NUM_WIN-1:0] en_vec;
    win_cfg_t         rd_win;

    assign wr_idx = wr_addr[AW-1:3];
    assign rd_idx = rd_addr[AW-1:3];

    // Update the addressed window's base or size fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_WIN; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    if (wr_addr[2]) begin
                        cfg[i].size_code <= wr_data[REG_W-1:GRAN_LSB];
                        cfg[i].cs        <= wr_data[CS_LSB+CS_W-1:CS_LSB];
                        cfg[i].en        <= wr_data[EN_BIT];
                    end else begin
                        cfg[i].base_lo   <= wr_data[REG_W-1:GRAN_LSB];
                        cfg[i].base_hi   <= wr_data[HI_W-1:0];
                    end
                end
            end
        end
    end

    // Build the read image of the selected register with undefined bits zero.
    always_comb begin
        rd_win = cfg[rd_idx];
        if (rd_addr[2]) begin
            rd_data = {rd_win.size_code, {(GRAN_LSB-CS_LSB-CS_W){1'b0}},
                       rd_win.cs, 1'b0, rd_win.en};
        end else begin
            rd_data = {rd_win.base_lo, {(GRAN_LSB-HI_W){1'b0}}, rd_win.base_hi};
        end
    end

    // Gather enables for the reset check.
    always_comb begin
        for (int i = 0; i < NUM_WIN; i++) en_vec[i] = cfg[i].en;
    end

    // R1: a reset cycle leaves every window disabled.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (en_vec == '0));

    // R2: configuration only moves when a write is presented.
    p_hold_nowrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg));

endmodule

// File: rtl/csw_win_match.sv
// Module: per-window address comparators.
// Each window compares the high nibble exactly and the 16 MiB byte under the
// inverse of its size code; disabled windows never match. Also flags windows
// whose base lies below 4 GiB. Purely combinational.
module csw_win_match #(
    parameter int NUM_WIN = 4
) (
    input  csw_pkg::win_cfg_t [NUM_WIN-1:0]     cfg,
    input  logic [csw_pkg::ADDR_W-1:0]          addr,
    output logic [NUM_WIN-1:0]                  match_vec,
    output logic [NUM_WIN-1:0]                  lo4g
);
    import csw_pkg::*;

    logic [HI_W-1:0] addr_hi;
    logic [LO_W-1:0] addr_lo;

    assign addr_hi = addr[ADDR_W-1:32];
    assign addr_lo = addr[31:GRAN_LSB];

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic hi_eq;
        logic lo_eq;
        // Exact compare of the bits above 4 GiB.
        assign hi_eq = (addr_hi == cfg[g].base_hi);
        // Masked compare of the 16 MiB granule bits.
        assign lo_eq = (((addr_lo ^ cfg[g].base_lo) & ~cfg[g].size_code) == '0);
        assign match_vec[g] = cfg[g].en & hi_eq & lo_eq;
        assign lo4g[g]      = (cfg[g].base_hi == '0);
    end

endmodule

// File: rtl/csw_pick.sv
// Module: priority pick and result register.
// Chooses the lowest matching window, forms its chip-select and attribute,
// and registers the result one cycle after the request. Assumes NUM_WIN <= 4
// so the window mask fits the attribute nibble.
module csw_pick #(
    parameter int NUM_WIN = 4,
    parameter int IDX_W   = $clog2(NUM_WIN)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                lookup_valid,
    input  logic                                coh_en,
    input  logic [NUM_WIN-1:0]                  match_vec,
    input  csw_pkg::win_cfg_t [NUM_WIN-1:0]     cfg,
    output logic                                res_valid,
    output logic                                res_hit,
    output logic [csw_pkg::CS_W-1:0]            res_cs,
    output logic [csw_pkg::ATTR_W-1:0]          res_attr
);
    import csw_pkg::*;

    logic              any_hit;
    logic [IDX_W-1:0]  sel;
    logic [CS_W-1:0]   cs_n;
    logic [ATTR_W-1:0] attr_n;
    logic [MASK_W-1:0] onehot;

    // Lowest set match bit wins: scan from the top so lower indices override.
    always_comb begin
        sel = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (match_vec[i]) sel = IDX_W'(i);
        end
    end

    assign any_hit = |match_vec;

    // Form chip-select and attribute for the selected window, zero on a miss.
    always_comb begin
        onehot = MASK_W'(1) << sel;
        attr_n = '0;
        cs_n   = '0;
        if (any_hit) begin
            attr_n[MASK_W-1:0] = ~onehot;
            attr_n[COH_BIT]    = coh_en;
            cs_n               = cfg[sel].cs;
        end
    end

    // Register the result for one-cycle lookup latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_cs    <= '0;
            res_attr  <= '0;
        end else begin
            res_valid <= lookup_valid;
            if (lookup_valid) begin
                res_hit  <= any_hit;
                res_cs   <= cs_n;
                res_attr <= attr_n;
            end
        end
    end

    // R8: a request produces a result exactly one cycle later, and only then.
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |=> res_valid);
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_valid |=> !res_valid);

    // R7: a miss reports nothing else.
    p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_cs == '0 && res_attr == '0));

    // R6: a hit clears exactly one mask bit and leaves the top bits zero.
    p_attr_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> ($countones(res_attr[MASK_W-1:0]) == MASK_W - 1
                                    && res_attr[ATTR_W-1:COH_BIT+1] == '0));

    // R6: the coherency flag follows the pin as sampled with the request.
    p_coh_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && any_hit) |=> (res_hit && res_attr[COH_BIT] == $past(coh_en)));

endmodule

// File: rtl/csw_count.sv
// Module: counts enabled windows that start below 4 GiB.
// Combinational from the register state, so it settles in the cycle after
// any write that changes an enable or a base high nibble.
module csw_count #(
    parameter int NUM_WIN = 4,
    parameter int CNT_W   = $clog2(NUM_WIN + 1)
) (
    input  csw_pkg::win_cfg_t [NUM_WIN-1:0]     cfg,
    input  logic [NUM_WIN-1:0]                  lo4g,
    output logic [CNT_W-1:0]                    num_cs
);
    // Sum the windows that are both enabled and reachable by 32-bit DMA.
    always_comb begin
        num_cs = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (cfg[i].en && lo4g[i]) num_cs = num_cs + CNT_W'(1);
        end
    end

endmodule

// File: rtl/dram_cs_decoder.sv
// Module: top of the DRAM chip-select window decoder.
// Ties the register file, comparators, priority pick and counter together.
// Assumes a synchronous active-low reset and NUM_WIN a power of two, 2..4.
module dram_cs_decoder #(
    parameter int NUM_WIN = 4,
    localparam int IDX_W  = $clog2(NUM_WIN),
    localparam int AW     = IDX_W + 3,
    localparam int CNT_W  = $clog2(NUM_WIN + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_wr_en,
    input  logic [AW-1:0]                   cfg_wr_addr,
    input  logic [csw_pkg::REG_W-1:0]       cfg_wr_data,
    input  logic [AW-1:0]                   cfg_rd_addr,
    output logic [csw_pkg::REG_W-1:0]       cfg_rd_data,
    input  logic                            coh_en,
    input  logic                            lookup_valid,
    input  logic [csw_pkg::ADDR_W-1:0]      lookup_addr,
    output logic                            res_valid,
    output logic                            res_hit,
    output logic [csw_pkg::CS_W-1:0]        res_cs,
    output logic [csw_pkg::ATTR_W-1:0]      res_attr,
    output logic [NUM_WIN-1:0]              win_lo4g,
    output logic [CNT_W-1:0]                num_cs
);
    import csw_pkg::*;

    win_cfg_t [NUM_WIN-1:0] cfg;
    logic [NUM_WIN-1:0]     match_vec;

    csw_regfile #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_wr_addr),
        .wr_data (cfg_wr_data),
        .rd_addr (cfg_rd_addr),
        .rd_data (cfg_rd_data),
        .cfg     (cfg)
    );

    csw_win_match #(.NUM_WIN(NUM_WIN)) u_match (
        .cfg       (cfg),
        .addr      (lookup_addr),
        .match_vec (match_vec),
        .lo4g      (win_lo4g)
    );

    csw_pick #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_pick (
        .clk          (clk),
        .rst_n        (rst_n),
        .lookup_valid (lookup_valid),
        .coh_en       (coh_en),
        .match_vec    (match_vec),
        .cfg          (cfg),
        .res_valid    (res_valid),
        .res_hit      (res_hit),
        .res_cs       (res_cs),
        .res_attr     (res_attr)
    );

    csw_count #(.NUM_WIN(NUM_WIN), .CNT_W(CNT_W)) u_count (
        .cfg    (cfg),
        .lo4g   (win_lo4g),
        .num_cs (num_cs)
    );

    // R10: the count only moves after a register write.
    p_count_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_en |=> $stable(num_cs));

    // R10: the count never exceeds the set of DMA-reachable windows.
    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        num_cs <= CNT_W'($countones(win_lo4g)));

endmodule

// File: tb/dram_cs_decoder_bench.sv
// Scoreboard bench: lookup driver queues expected results from a shadow of
// the programmed registers; a monitor pops and compares on each result.
`timescale 1ns/1ps
module dram_cs_decoder_bench;

    localparam real CLK_NS = 8.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [4:0]  cfg_wr_addr = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [4:0]  cfg_rd_addr = '0;
    logic [31:0] cfg_rd_data;
    logic        coh_en = 1'b0;
    logic        lookup_valid = 1'b0;
    logic [35:0] lookup_addr = '0;
    logic        res_valid, res_hit;
    logic [2:0]  res_cs;
    logic [7:0]  res_attr;
    logic [3:0]  win_lo4g;
    logic [2:0]  num_cs;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] sh_base [4];
    logic [31:0] sh_size [4];

    typedef struct packed {
        logic [11:0] v;     // {hit, cs[2:0], attr[7:0]}
        logic [35:0] a;
        int          req;
    } exp_t;
    exp_t sbq [$];

    always #(CLK_NS/2) clk = ~clk;

    dram_cs_decoder u_dram_cs_decoder (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
        .coh_en(coh_en), .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
        .res_valid(res_valid), .res_hit(res_hit), .res_cs(res_cs), .res_attr(res_attr),
        .win_lo4g(win_lo4g), .num_cs(num_cs)
    );

    // Expected result from the requirement text: range test, lowest index first.
    function automatic logic [11:0] expect_res(input logic [35:0] a, input logic c);
        logic [39:0] lo, len;
        for (int i = 0; i < 4; i++) begin
            if (sh_size[i][0]) begin
                lo  = {4'h0, sh_base[i][3:0], sh_base[i][31:24], 24'h0};
                len = (40'(sh_size[i][31:24]) + 40'd1) << 24;
                if ({4'h0, a} >= lo && {4'h0, a} < lo + len)
                    return {1'b1, sh_size[i][4:2], 3'b000, c, 4'hF & ~(4'b1 << i)};
            end
        end
        return 12'h000;
    endfunction

    function automatic logic [2:0] expect_cnt();
        logic [2:0] n = 0;
        for (int i = 0; i < 4; i++)
            if (sh_size[i][0] && sh_base[i][3:0] == 4'h0) n = n + 3'd1;
        return n;
    endfunction

    task automatic check(input logic [35:0] act, input logic [35:0] expv, input string what);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, expv);
        end
    endtask

    task automatic wr(input logic [4:0] addr, input logic [31:0] data);
        @(negedge clk);
        lookup_valid = 1'b0;
        cfg_wr_en    = 1'b1;
        cfg_wr_addr  = addr;
        cfg_wr_data  = data;
        if (addr[2]) sh_size[addr[4:3]] = data & 32'hFF00001D;
        else         sh_base[addr[4:3]] = data & 32'hFF00000F;
    endtask

    task automatic lk(input logic [35:0] a, input logic c, input int req);
        exp_t e;
        @(negedge clk);
        cfg_wr_en    = 1'b0;
        lookup_valid = 1'b1;
        lookup_addr  = a;
        coh_en       = c;
        e.v = expect_res(a, c); e.a = a; e.req = req;
        sbq.push_back(e);
    endtask

    // R11: write and lookup in one cycle; lookup sees the old registers.
    task automatic wr_lk(input logic [4:0] addr, input logic [31:0] data, input logic [35:0] a);
        exp_t e;
        @(negedge clk);
        lookup_valid = 1'b1;
        lookup_addr  = a;
        coh_en       = 1'b0;
        e.v = expect_res(a, 1'b0); e.a = a; e.req = 11;
        sbq.push_back(e);
        cfg_wr_en   = 1'b1;
        cfg_wr_addr = addr;
        cfg_wr_data = data;
        if (addr[2]) sh_size[addr[4:3]] = data & 32'hFF00001D;
        else         sh_base[addr[4:3]] = data & 32'hFF00000F;
    endtask

    task automatic idle();
        @(negedge clk);
        cfg_wr_en    = 1'b0;
        lookup_valid = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] addr, input logic [31:0] expv, input string what);
        @(negedge clk);
        cfg_wr_en    = 1'b0;
        lookup_valid = 1'b0;
        cfg_rd_addr  = addr;
        #1;
        check(36'(cfg_rd_data), 36'(expv), what);
    endtask

    // Monitor: compare each produced result against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            exp_t e;
            n_checks++;
            if (sbq.size() == 0) begin
                n_fail++;
                $display("FAIL R8: unexpected result actual %0h expected none",
                         {res_hit, res_cs, res_attr});
            end else begin
                e = sbq.pop_front();
                if ({res_hit, res_cs, res_attr} !== e.v) begin
                    n_fail++;
                    $display("FAIL R%0d: addr %09h actual %03h expected %03h",
                             e.req, e.a, {res_hit, res_cs, res_attr}, e.v);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin sh_base[i] = '0; sh_size[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        idle();
        check(36'(num_cs), 36'd0, "R1 num_cs after reset");
        check(36'(win_lo4g), 36'hF, "R1/R9 lo4g after reset");
        rd_chk(5'h04, 32'h0, "R1 size reg after reset");
        lk(36'h0_0000_0000, 1'b0, 1);          // R1: miss
        idle();

        // Window 0: base 0, 256 MiB, cs 0.
        wr(5'h00, 32'h0000_0000);
        wr(5'h04, 32'h0F00_0001);
        idle();
        check(36'(num_cs), 36'(expect_cnt()), "R10 count after window 0");
        lk(36'h0_0800_0000, 1'b0, 3);          // R3 hit inside
        lk(36'h0_0FFF_FFFF, 1'b1, 6);          // R6 coherency set
        lk(36'h0_1000_0000, 1'b0, 3);          // R3 just past end: miss
        idle();

        // Window 1: base 256 MiB, 256 MiB, cs 1.
        wr(5'h08, 32'h1000_0000);
        wr(5'h0C, 32'h0F00_0005);
        // Window 2: base 4 GiB, 1 GiB, cs 2 (not DMA reachable).
        wr(5'h10, 32'h0000_0001);
        wr(5'h14, 32'h3F00_0009);
        idle();
        check(36'(win_lo4g), 36'b1011, "R9 window 2 above 4 GiB");
        check(36'(num_cs), 36'd2, "R10 window 2 not counted");
        lk(36'h0_1FFF_FFFF, 1'b0, 3);          // R3 window 1 last byte
        lk(36'h1_3000_0000, 1'b1, 6);          // R6 window 2 hit, mask 0xB
        lk(36'h1_4000_0000, 1'b0, 7);          // R7 past window 2: miss
        lk(36'h0_3000_0000, 1'b0, 3);          // R3 high nibble matters: miss
        idle();

        // Window 3 overlaps window 0: base 0, 16 MiB, cs 5.
        wr(5'h18, 32'h0000_0000);
        wr(5'h1C, 32'h0000_0015);
        idle();
        check(36'(num_cs), 36'd3, "R10 count with window 3");
        lk(36'h0_00FF_FFFF, 1'b0, 5);          // R5 window 0 beats window 3
        idle();

        // R4: disable window 0, the same address now falls to window 3.
        wr(5'h04, 32'h0F00_0000);
        idle();
        check(36'(num_cs), 36'd2, "R10 count after disable");
        lk(36'h0_00FF_FFFF, 1'b1, 4);          // R4/R5 window 3 wins, mask 0x7
        lk(36'h0_0100_0000, 1'b0, 4);          // R4 disabled window 0 area: miss
        lk(36'h0_0800_0000, 1'b0, 4);          // R4 back-to-back, still miss
        idle();
        idle();
        check(36'(res_valid), 36'd0, "R8 no result without request");

        // R11: re-enable window 0 in the same cycle as a lookup into it.
        wr_lk(5'h04, 32'h0F00_0001, 36'h0_0200_0000);
        lk(36'h0_0200_0000, 1'b0, 11);         // R11 next cycle sees the write
        idle();

        // R2: field masking and ignored low offset bits.
        wr(5'h1F, 32'hFFFF_FFFF);              // window 3 size, bits 1:0 set
        wr(5'h1B, 32'hFFFF_FFFF);              // window 3 base, bits 1:0 set
        idle();
        rd_chk(5'h1C, 32'hFF00_001D, "R2 size readback masked");
        rd_chk(5'h18, 32'hFF00_000F, "R2 base readback masked");
        check(36'(win_lo4g[3]), 36'd0, "R9 window 3 moved above 4 GiB");
        check(36'(num_cs), 36'(expect_cnt()), "R10 count after window 3 moved");
        lk(36'hF_FFFF_FFFF, 1'b0, 3);          // R3 window 3 code 0xFF, cs 7
        idle();
        idle();
        check(36'(sbq.size()), 36'd0, "R8 every request answered");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule